// File: doc/BRIEF.md
# Password-Unlocked Flash Test Control Register

This block is one 32-bit control and status word. It guards a user test mode for an ECC-protected flash array. Software reaches it through a plain synchronous write/read port. The test mode stays disabled until software writes one fixed 32-bit key while neither a program request nor an erase request is pending. While the mode is disabled, every writable field here is frozen. A lock output carries the same freeze to the sibling test and signature registers.

Once the mode is on, software can set the following controls:

- the correction-observe enable;
- the 8-bit syndrome override passed to the ECC logic;
- the margin read controls;
- the check-engine controls.

Leaving the mode is interlocked with the array check engine. The enable clears only while the engine reports idle and no check is armed. A write that clears the enable cannot arm a check in the same write.

The register port carries no data stream, so it has no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read is combinational and answers in the cycle of `rd_en`. All other pins are plain levels.

Top module: `flash_utest_ctl`

## Requirements

Bit layout of the register image:

| Bits | Field | Software access |
|------|-------|-----------------|
| 31 | test enable | set by key, clear by write |
| 30 | correction-observe enable | read/write |
| 23:16 | syndrome override | read/write |
| 9 | ECC algorithm status | read-only |
| 5 | margin enable | read/write, gated |
| 4 | margin value | read/write |
| 3 | ECC-check enable | read/write |
| 2 | check select | read/write |
| 1 | check enable | read/write |
| 0 | check-done | read-only |

All other bits are reserved.

- R1: After reset, every stored field is 0 and `sib_lock` is 1. With `chk_idle`=1 and `algo_sts`=0, the image reads 0x0000_0001.
- R2: The test enable (bit 31) becomes 1 only through a write whose data is exactly 0xF9F9_9999. Writing any other value, including one with bit 31 set, leaves it at 0.
- R3: A key write is ignored while `pgm_req` or `ers_req` is 1. An accepted key write loads no other field from its data.
- R4: Once set, the test enable stays 1 until a write with bit 31 = 0 clears it. Such a clear takes effect only when check-done is 1, check enable is 0 and ECC-check enable is 0 at that write. If the clear is refused, the other writable fields of that write still load.
- R5: In a write that clears the test enable, data bits 1 (check enable) and 3 (ECC-check enable) are ignored, and both fields stay 0.
- R6: While the test enable is 0, every write other than an accepted key write leaves all fields unchanged. `sib_lock` equals the inverse of the test enable.
- R7: The margin enable (bit 5) is not written while check-done is 0. The other fields of the same write still load.
- R8: Data bits 23:16 load the syndrome override, which drives `syndrome` unchanged.
- R9: Bit 9 reflects `algo_sts` and bit 0 reflects `chk_idle`. Software cannot write either bit. Reserved bits read 0.
- R10: `rdata` shows the current image in the cycle `rd_en` is 1, and reads 0 otherwise.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 32 | Read data, 0 when not reading |
| pgm_req | input | 1 | Program operation requested |
| ers_req | input | 1 | Erase operation requested |
| chk_idle | input | 1 | Array check engine idle (check-done) |
| algo_sts | input | 1 | ECC code type: 0 Hamming, 1 Hsiao |
| test_en | output | 1 | Test mode enabled |
| sib_lock | output | 1 | Write lock for sibling test registers |
| corr_obs_en | output | 1 | Single-bit correction observe enable |
| syndrome | output | 8 | Syndrome check bits for the ECC logic |
| margin_en | output | 1 | Margin read enable |
| margin_val | output | 1 | Margin level select |
| ecc_chk_en | output | 1 | ECC-check enable |
| chk_sel | output | 1 | Check sequence select |
| chk_en | output | 1 | Array check enable |

## Verification

Four properties are checked on every cycle:

- the enable rises only after an accepted key write;
- a key write under a pending program or erase request is refused;
- a refused clear leaves the enable set;
- a disabled register and a non-idle engine freeze their fields, and a clearing write leaves both check enables at 0.

Other behaviours only the bench scenarios can show:

- that an accepted key leaves the other fields untouched;
- that a refused clear still loads the other fields;
- that reserved bits read 0;
- that the read-only status bits follow their inputs;
- that the read port returns 0 outside a read.

// File: rtl/flash_utest_pkg.sv
package flash_utest_pkg;

  localparam int REG_W = 32;
  localparam int SYN_W = 8;

  // bit positions inside the register image
  localparam int B_TEN  = 31;
  localparam int B_CORR = 30;
  localparam int B_SYN  = 16;
  localparam int B_ALGO = 9;
  localparam int B_MEN  = 5;
  localparam int B_MVAL = 4;
  localparam int B_ECHK = 3;
  localparam int B_CSEL = 2;
  localparam int B_CEN  = 1;
  localparam int B_DONE = 0;

  localparam logic [REG_W-1:0] UNLOCK_KEY = 32'hF9F9_9999;

  typedef struct packed {
    logic             corr_obs;
    logic [SYN_W-1:0] syn;
    logic             margin_en;
    logic             margin_val;
    logic             ecc_chk_en;
    logic             chk_sel;
    logic             chk_en;
  } utest_fields_t;

endpackage

// File: rtl/flash_utest_unlock.sv
module flash_utest_unlock
  import flash_utest_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             pgm_req,
  input  logic             ers_req,
  input  logic             chk_done,
  input  logic             chk_en_q,
  input  logic             ecc_chk_q,
  output logic             ten_q,
  output logic             field_we,
  output logic             clr_ok
);

  logic key_hit;
  logic key_take;
  logic clr_req;

  always_comb begin
    key_hit  = wr_en && (wdata == KEY);
    key_take = key_hit && !pgm_req && !ers_req;
    clr_req  = wr_en && !key_hit && ten_q && !wdata[B_TEN];
    clr_ok   = clr_req && chk_done && !chk_en_q && !ecc_chk_q;
    field_we = wr_en && !key_hit && ten_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ten_q <= 1'b0;
    else if (key_take) ten_q <= 1'b1;
    else if (clr_ok)   ten_q <= 1'b0;
  end

  // R2: enable never rises without the key on the write port
  p_set_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ten_q && !(wr_en && wdata == KEY)) |=> !ten_q);

  // R3: key refused while program or erase pending
  p_key_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ten_q && wr_en && wdata == KEY && (pgm_req || ers_req)) |=> !ten_q);

  // R4: enable holds unless the check engine is idle and disarmed
  p_clear_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_q && !(chk_done && !chk_en_q && !ecc_chk_q)) |=> ten_q);

endmodule

// File: rtl/flash_utest_fields.sv
module flash_utest_fields
  import flash_utest_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_we,
  input  logic             clr_ok,
  input  logic             chk_done,
  input  logic             ten_q,
  input  logic [REG_W-1:0] wdata,
  output utest_fields_t    f_q
);

  utest_fields_t f_d;

  always_comb begin
    f_d = f_q;
    if (field_we) begin
      f_d.corr_obs   = wdata[B_CORR];
      f_d.syn        = wdata[B_SYN +: SYN_W];
      f_d.margin_val = wdata[B_MVAL];
      f_d.chk_sel    = wdata[B_CSEL];
      if (chk_done) f_d.margin_en = wdata[B_MEN];
      if (clr_ok) begin
        f_d.chk_en     = 1'b0;
        f_d.ecc_chk_en = 1'b0;
      end else begin
        f_d.chk_en     = wdata[B_CEN];
        f_d.ecc_chk_en = wdata[B_ECHK];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  // R6: nothing moves while the test mode is off
  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ten_q |=> $stable(f_q));

  // R7: margin enable frozen while the check engine is busy
  p_margin_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_done |=> $stable(f_q.margin_en));

  // R5: a clearing write leaves both check enables low
  p_clear_noset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> (!f_q.chk_en && !f_q.ecc_chk_en));

endmodule

// File: rtl/flash_utest_readback.sv
module flash_utest_readback
  import flash_utest_pkg::*;
(
  input  logic             rd_en,
  input  logic             ten_q,
  input  utest_fields_t    f_q,
  input  logic             algo_sts,
  input  logic             chk_done,
  output logic [REG_W-1:0] rdata
);

  logic [REG_W-1:0] image;

  always_comb begin
    image                 = '0;
    image[B_TEN]          = ten_q;
    image[B_CORR]         = f_q.corr_obs;
    image[B_SYN +: SYN_W] = f_q.syn;
    image[B_ALGO]         = algo_sts;
    image[B_MEN]          = f_q.margin_en;
    image[B_MVAL]         = f_q.margin_val;
    image[B_ECHK]         = f_q.ecc_chk_en;
    image[B_CSEL]         = f_q.chk_sel;
    image[B_CEN]          = f_q.chk_en;
    image[B_DONE]         = chk_done;
    rdata                 = rd_en ? image : '0;
  end

endmodule

// File: rtl/flash_utest_ctl.sv
module flash_utest_ctl
  import flash_utest_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             rd_en,
  output logic [REG_W-1:0] rdata,
  input  logic             pgm_req,
  input  logic             ers_req,
  input  logic             chk_idle,
  input  logic             algo_sts,
  output logic             test_en,
  output logic             sib_lock,
  output logic             corr_obs_en,
  output logic [SYN_W-1:0] syndrome,
  output logic             margin_en,
  output logic             margin_val,
  output logic             ecc_chk_en,
  output logic             chk_sel,
  output logic             chk_en
);

  logic          ten_q;
  logic          field_we;
  logic          clr_ok;
  utest_fields_t f_q;

  flash_utest_unlock #(.KEY(KEY)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .pgm_req   (pgm_req),
    .ers_req   (ers_req),
    .chk_done  (chk_idle),
    .chk_en_q  (f_q.chk_en),
    .ecc_chk_q (f_q.ecc_chk_en),
    .ten_q     (ten_q),
    .field_we  (field_we),
    .clr_ok    (clr_ok)
  );

  flash_utest_fields u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .field_we (field_we),
    .clr_ok   (clr_ok),
    .chk_done (chk_idle),
    .ten_q    (ten_q),
    .wdata    (wdata),
    .f_q      (f_q)
  );

  flash_utest_readback u_read (
    .rd_en    (rd_en),
    .ten_q    (ten_q),
    .f_q      (f_q),
    .algo_sts (algo_sts),
    .chk_done (chk_idle),
    .rdata    (rdata)
  );

  always_comb begin
    test_en     = ten_q;
    sib_lock    = !ten_q;
    corr_obs_en = f_q.corr_obs;
    syndrome    = f_q.syn;
    margin_en   = f_q.margin_en;
    margin_val  = f_q.margin_val;
    ecc_chk_en  = f_q.ecc_chk_en;
    chk_sel     = f_q.chk_sel;
    chk_en      = f_q.chk_en;
  end

endmodule

// File: tb/flash_utest_ctl_test.sv
module flash_utest_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        pgm_req = 1'b0;
  logic        ers_req = 1'b0;
  logic        chk_idle = 1'b1;
  logic        algo_sts = 1'b0;
  logic        test_en, sib_lock, corr_obs_en, margin_en, margin_val;
  logic        ecc_chk_en, chk_sel, chk_en;
  logic [7:0]  syndrome;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_utest_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .pgm_req(pgm_req), .ers_req(ers_req), .chk_idle(chk_idle),
    .algo_sts(algo_sts), .test_en(test_en), .sib_lock(sib_lock),
    .corr_obs_en(corr_obs_en), .syndrome(syndrome), .margin_en(margin_en),
    .margin_val(margin_val), .ecc_chk_en(ecc_chk_en), .chk_sel(chk_sel),
    .chk_en(chk_en)
  );

  // vector: {req[3:0], wdata[31:0], pgm, ers, idle, expected image[31:0]}
  localparam int NV = 17;
  localparam logic [70:0] VEC [NV] = '{
    {4'd6, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0000_0001},
    {4'd2, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0001},
    {4'd3, 32'hF9F9_9999, 1'b1, 1'b0, 1'b1, 32'h0000_0001},
    {4'd3, 32'hF9F9_9999, 1'b0, 1'b1, 1'b1, 32'h0000_0001},
    {4'd2, 32'hF9F9_9999, 1'b0, 1'b0, 1'b1, 32'h8000_0001},
    {4'd8, 32'h80AB_0000, 1'b0, 1'b0, 1'b1, 32'h80AB_0001},
    {4'd7, 32'h80AB_0030, 1'b0, 1'b0, 1'b0, 32'h80AB_0010},
    {4'd7, 32'h80AB_0030, 1'b0, 1'b0, 1'b1, 32'h80AB_0031},
    {4'd4, 32'hC000_0002, 1'b0, 1'b0, 1'b1, 32'hC000_0003},
    {4'd4, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h8000_0001},
    {4'd4, 32'h8000_0008, 1'b0, 1'b0, 1'b1, 32'h8000_0009},
    {4'd4, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h8000_0001},
    {4'd4, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h8000_0000},
    {4'd5, 32'h0000_000E, 1'b0, 1'b0, 1'b1, 32'h0000_0005},
    {4'd6, 32'h40FF_003E, 1'b0, 1'b0, 1'b1, 32'h0000_0005},
    {4'd2, 32'hF9F9_9999, 1'b0, 1'b0, 1'b1, 32'h8000_0005},
    {4'd9, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'hC0FF_003F}
  };

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(output logic [31:0] v);
    rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    do_read(v);
    check("R1", v, 32'h0000_0001);
    check("R1", {31'd0, sib_lock}, 32'd1);
    check("R1", {31'd0, test_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: no read strobe, no data
    #1 check("R10", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pgm_req  = VEC[i][34];
      ers_req  = VEC[i][33];
      chk_idle = VEC[i][32];
      do_write(VEC[i][66:35]);
      do_read(v);
      check($sformatf("R%0d", VEC[i][70:67]), v, VEC[i][31:0]);
    end

    // R6: lock output follows enable (enabled now)
    check("R6", {31'd0, sib_lock}, 32'd0);
    // R8: syndrome port carries the loaded value
    do_write(32'h805A_0000);
    check("R8", {24'd0, syndrome}, 32'h0000_005A);
    // R9: algorithm status read-only, follows its input
    algo_sts = 1'b1;
    do_write(32'h805A_0000);
    do_read(v);
    check("R9", v, 32'h805A_0201);
    do_write(32'h805A_0000 & ~32'h0000_0200);
    algo_sts = 1'b0;
    do_read(v);
    check("R9", v, 32'h805A_0001);
    // R3: key while enabled loads no fields
    do_write(32'hF9F9_9999);
    do_read(v);
    check("R3", v, 32'h805A_0001);
    // R5/R6: clear then lock output asserted
    do_write(32'h0000_000A);
    check("R5", {30'd0, chk_en, ecc_chk_en}, 32'd0);
    check("R6", {31'd0, sib_lock}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule